// File: doc/BRIEF.md
# Video Plane Start-Address Register Bank

This block holds the start offsets of the video buffers that a display controller fetches from, and turns them into the per-frame base addresses for the luma and two chroma planes. A host reaches the bank through a simple single-cycle read/write bus of 32-bit words. Every write lands in a pending copy. The fetch logic only sees the new values once a frame or interlaced-field start strobe arrives, so a base address never changes partway through a picture.

A format bit in a configuration word picks between two layouts. In packed 4:2:2 form, one buffer carries interleaved luma and chroma, so only the luma base is meaningful. In planar 4:2:0 form, each of the three planes has its own buffer. A small field counter can also step the luma base across several frame buffers that sit back to back in memory. Each strobe moves the base one buffer stride further and wraps after a programmed number of buffers, with no host action. Every emitted base is forced onto a 32-byte boundary.

Top module: `vid_plane_addr_bank`

## Requirements
- R1: After reset, every output and every register read returns zero: all bases, the field count, the mode flag and `rdata`.
- R2: A write to byte address 0x20 stores all 32 bits: bits 27:0 are the luma offset and bits 31:28 are the buffer-count limit. A write to 0x24 (first chroma) or 0x28 (second chroma) stores bits 27:0, and those registers read 0 in bits 31:28. A write to 0x04 stores only bit 20, the planar flag; reads of 0x04 return that bit in position 20 and zero elsewhere. `rdata` shows the pending value one cycle after `rd_en`, and holds its value otherwise.
- R3: A write changes none of `y_base`, `u_base`, `v_base`, `field_cnt` or `planar` until `frame_start` is sampled high. In the cycle after that strobe, the outputs reflect the pending values.
- R4: A write sampled in the same cycle as `frame_start` is not committed by that strobe. It is committed by the next one.
- R5: Bits 4:0 of every emitted base are zero, whatever was written.
- R6: With the committed planar flag at 0 (packed 4:2:2), `u_base` and `v_base` are 0, whatever the chroma offsets hold.
- R7: With the committed planar flag at 1 (planar 4:2:0), `u_base` and `v_base` equal the committed chroma offsets with bits 4:0 cleared.
- R8: At each strobe, let L be the limit being committed from bits 31:28 of register 0x20. The field count becomes 0 if L is 0 or 1. Otherwise it becomes count+1, or 0 when count+1 ≥ L. The count is shown on `field_cnt` and stays unchanged between strobes.
- R9: At each strobe, `y_base` becomes (luma offset + new count × `frame_size`) modulo 2^28, with bits 4:0 cleared. `frame_size` is sampled in the strobe cycle.
- R10: A read of any other address returns 0. A write to any other address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the host bus |
| rd_en | input | 1 | Read strobe for the host bus |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after `rd_en` |
| frame_start | input | 1 | Frame or field start strobe; commits the pending values |
| frame_size | input | 28 | Byte stride between contiguous frame buffers |
| y_base | output | 28 | Active luma (or packed) fetch base |
| u_base | output | 28 | Active first-chroma fetch base |
| v_base | output | 28 | Active second-chroma fetch base |
| field_cnt | output | 4 | Current field counter |
| planar | output | 1 | Active format flag, 1 = planar 4:2:0 |

## Verification
There is exactly one register between each input and each result. Read data appears in the cycle after `rd_en`. The bases, count and mode appear in the cycle after the strobe is sampled. A write alone never reaches the active outputs. The scoreboard stamps every expected item with the cycle it is due, one after the stimulus. The monitor compares items only in that cycle, at a falling edge, once the rising-edge update has settled. Cycles without a strobe are also checked, to show that the outputs keep their value across writes.

// File: rtl/vpab_pkg.sv
package vpab_pkg;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 32;
    localparam int OFS_W    = 28;
    localparam int CNT_W    = 4;
    localparam int ALIGN_W  = 5;
    localparam int MODE_BIT = 20;

    localparam logic [ADDR_W-1:0] REG_CFG = 8'h04;
    localparam logic [ADDR_W-1:0] REG_Y   = 8'h20;
    localparam logic [ADDR_W-1:0] REG_U   = 8'h24;
    localparam logic [ADDR_W-1:0] REG_V   = 8'h28;

    typedef struct packed {
        logic [CNT_W-1:0] lim;
        logic [OFS_W-1:0] y;
        logic [OFS_W-1:0] u;
        logic [OFS_W-1:0] v;
        logic             planar;
    } pend_t;

    function automatic logic [OFS_W-1:0] align_ofs(input logic [OFS_W-1:0] a);
        return {a[OFS_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
    endfunction
endpackage

// File: rtl/vpab_regfile.sv
module vpab_regfile
    import vpab_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output pend_t             pend,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        pend_t             pend;
        logic [DATA_W-1:0] rdata;
    } rf_t;

    rf_t st_d, st_q;
    logic [DATA_W-1:0] rd_mux;
    logic              hit;

    always_comb begin
        hit    = 1'b1;
        rd_mux = '0;
        case (addr)
            REG_CFG: rd_mux = DATA_W'(st_q.pend.planar) << MODE_BIT;
            REG_Y:   rd_mux = {st_q.pend.lim, st_q.pend.y};
            REG_U:   rd_mux = {{(DATA_W-OFS_W){1'b0}}, st_q.pend.u};
            REG_V:   rd_mux = {{(DATA_W-OFS_W){1'b0}}, st_q.pend.v};
            default: hit = 1'b0;
        endcase

        st_d = st_q;
        if (rd_en) st_d.rdata = rd_mux;
        if (wr_en) begin
            case (addr)
                REG_CFG: st_d.pend.planar = wdata[MODE_BIT];
                REG_Y:   {st_d.pend.lim, st_d.pend.y} = wdata;
                REG_U:   st_d.pend.u = wdata[OFS_W-1:0];
                REG_V:   st_d.pend.v = wdata[OFS_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend  = st_q.pend;
    assign rdata = st_q.rdata;

    // R2: a luma write is visible in the pending copy on the next cycle
    p_wr_luma_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_Y) |=> (pend.y == $past(wdata[OFS_W-1:0])));

    // R10: an unmapped read returns zero
    p_unmapped_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !hit) |=> (rdata == '0));

    // R10: an unmapped write leaves the pending copy untouched
    p_unmapped_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hit) |=> $stable(pend));
endmodule

// File: rtl/vpab_field_ctr.sv
module vpab_field_ctr
    import vpab_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic [CNT_W-1:0] lim_new,
    output logic [CNT_W-1:0] cnt_next,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] inc;

    always_comb begin
        inc   = cnt_q + CNT_W'(1);
        cnt_d = cnt_q;
        if (strobe) begin
            if (lim_new <= CNT_W'(1))  cnt_d = '0;
            else if (inc >= lim_new)   cnt_d = '0;
            else                       cnt_d = inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_next = cnt_d;
    assign cnt      = cnt_q;

    // R8: the count moves only at a strobe
    p_cnt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(cnt_q));

    // R8: after a strobe with a limit above one, the count stays below it
    p_cnt_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && lim_new > CNT_W'(1)) |=> (cnt_q < $past(lim_new)));

    // R8: a limit of zero or one holds the count at zero
    p_cnt_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && lim_new <= CNT_W'(1)) |=> (cnt_q == '0));
endmodule

// File: rtl/vpab_commit.sv
module vpab_commit
    import vpab_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  pend_t            pend,
    input  logic [CNT_W-1:0] cnt_next,
    input  logic [OFS_W-1:0] frame_size,
    output logic [OFS_W-1:0] y_base,
    output logic [OFS_W-1:0] u_base,
    output logic [OFS_W-1:0] v_base,
    output logic             planar
);
    localparam int NCHROMA = 2;

    typedef struct packed {
        logic [OFS_W-1:0]               y;
        logic [NCHROMA-1:0][OFS_W-1:0]  c;
        logic                           planar;
    } act_t;

    act_t act_d, act_q;
    logic [OFS_W-1:0]              y_sum;
    logic [NCHROMA-1:0][OFS_W-1:0] c_src;
    logic [NCHROMA-1:0][OFS_W-1:0] c_new;

    assign c_src[0] = pend.u;
    assign c_src[1] = pend.v;

    for (genvar gi = 0; gi < NCHROMA; gi++) begin : g_chroma
        assign c_new[gi] = pend.planar ? align_ofs(c_src[gi]) : '0;
    end

    always_comb begin
        y_sum = pend.y + (OFS_W'(cnt_next) * frame_size);
        act_d = act_q;
        if (strobe) begin
            act_d.y      = align_ofs(y_sum);
            act_d.c      = c_new;
            act_d.planar = pend.planar;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) act_q <= '0;
        else        act_q <= act_d;
    end

    assign y_base = act_q.y;
    assign u_base = act_q.c[0];
    assign v_base = act_q.c[1];
    assign planar = act_q.planar;

    // R3: active values hold whenever no strobe is sampled
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> ($stable(y_base) && $stable(u_base) && $stable(v_base) && $stable(planar)));

    // R6: committing packed mode zeroes both chroma bases
    p_packed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !pend.planar) |=> (u_base == '0 && v_base == '0));

    // R3: the committed mode flag follows the pending one
    p_mode_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> (planar == $past(pend.planar)));
endmodule

// File: rtl/vid_plane_addr_bank.sv
module vid_plane_addr_bank
    import vpab_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              frame_start,
    input  logic [OFS_W-1:0]  frame_size,
    output logic [OFS_W-1:0]  y_base,
    output logic [OFS_W-1:0]  u_base,
    output logic [OFS_W-1:0]  v_base,
    output logic [CNT_W-1:0]  field_cnt,
    output logic              planar
);
    pend_t            pend;
    logic [CNT_W-1:0] cnt_next;

    vpab_regfile u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .pend  (pend),
        .rdata (rdata)
    );

    vpab_field_ctr u_fcnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe   (frame_start),
        .lim_new  (pend.lim),
        .cnt_next (cnt_next),
        .cnt      (field_cnt)
    );

    vpab_commit u_commit (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe     (frame_start),
        .pend       (pend),
        .cnt_next   (cnt_next),
        .frame_size (frame_size),
        .y_base     (y_base),
        .u_base     (u_base),
        .v_base     (v_base),
        .planar     (planar)
    );

    // R4: a write in a strobe cycle does not reach the luma base at that strobe
    p_coincident_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && wr_en && addr == REG_Y && pend.lim <= CNT_W'(1))
        |=> (y_base == align_ofs($past(pend.y))));
endmodule

// File: tb/tb_vid_plane_addr_bank.sv
module tb_vid_plane_addr_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        frame_start = 1'b0;
    logic [27:0] frame_size = '0;
    logic [27:0] y_base, u_base, v_base;
    logic [3:0]  field_cnt;
    logic        planar;

    vid_plane_addr_bank dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .frame_start(frame_start),
        .frame_size(frame_size), .y_base(y_base), .u_base(u_base),
        .v_base(v_base), .field_cnt(field_cnt), .planar(planar)
    );

    always #2 clk = ~clk;

    typedef struct {
        int          due;
        int          sel;
        logic [31:0] val;
        string       tag;
    } item_t;

    item_t q[$];
    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state, derived from the requirements
    logic [31:0] m_py;
    logic [27:0] m_pu, m_pv;
    logic        m_pm;
    logic [27:0] m_y, m_u, m_v;
    int          m_cnt;
    logic        m_mode;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [27:0] al(input logic [27:0] a);
        return {a[27:5], 5'b0};
    endfunction

    function automatic logic [31:0] rd_model(input logic [7:0] a);
        case (a)
            8'h04:   return {11'b0, m_pm, 20'b0};
            8'h20:   return m_py;
            8'h24:   return {4'b0, m_pu};
            8'h28:   return {4'b0, m_pv};
            default: return 32'h0;
        endcase
    endfunction

    task automatic push(input int sel, input logic [31:0] v, input string tag);
        item_t it;
        it.due = cyc + 1; it.sel = sel; it.val = v; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic push_outs(input string tag);
        push(1, {4'b0, m_y}, tag);
        push(2, {4'b0, m_u}, tag);
        push(3, {4'b0, m_v}, tag);
        push(4, 32'(m_cnt), tag);
        push(5, {31'b0, m_mode}, tag);
    endtask

    // driver: one bus cycle, updates the model and queues expected results
    task automatic step(input bit wr, input logic [7:0] a, input logic [31:0] d,
                        input bit rd, input bit fs, input bit chk, input string tag);
        int lim;
        wr_en = wr; rd_en = rd; addr = a; wdata = d; frame_start = fs;
        if (rd) push(0, rd_model(a), tag);
        if (fs) begin
            lim = int'(m_py[31:28]);
            if (lim <= 1) m_cnt = 0;
            else if (m_cnt + 1 >= lim) m_cnt = 0;
            else m_cnt = m_cnt + 1;
            m_y    = al(m_py[27:0] + 28'(m_cnt) * frame_size);
            m_mode = m_pm;
            m_u    = m_pm ? al(m_pu) : 28'h0;
            m_v    = m_pm ? al(m_pv) : 28'h0;
        end
        if (wr) begin
            case (a)
                8'h04: m_pm = d[20];
                8'h20: m_py = d;
                8'h24: m_pu = d[27:0];
                8'h28: m_pv = d[27:0];
                default: ;
            endcase
        end
        if (chk) push_outs(tag);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; frame_start = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        step(1'b1, a, d, 1'b0, 1'b0, 1'b0, "");
    endtask
    task automatic rd(input logic [7:0] a, input string tag);
        step(1'b0, a, 32'h0, 1'b1, 1'b0, 1'b0, tag);
    endtask
    task automatic strobe(input string tag);
        step(1'b0, 8'h00, 32'h0, 1'b0, 1'b1, 1'b1, tag);
    endtask

    // monitor: compares each expected item in the cycle it is due
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0 && q[0].due <= cyc) begin
                item_t it;
                logic [31:0] act;
                it = q.pop_front();
                case (it.sel)
                    0: act = rdata;
                    1: act = {4'b0, y_base};
                    2: act = {4'b0, u_base};
                    3: act = {4'b0, v_base};
                    4: act = {28'b0, field_cnt};
                    default: act = {31'b0, planar};
                endcase
                checks++;
                if (act !== it.val || it.due != cyc) begin
                    errors++;
                    $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, act, it.val);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        m_py = '0; m_pu = '0; m_pv = '0; m_pm = 1'b0;
        m_y = '0; m_u = '0; m_v = '0; m_cnt = 0; m_mode = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state of outputs and registers
        step(1'b0, 8'h00, 32'h0, 1'b0, 1'b0, 1'b1, "R1");
        rd(8'h04, "R1"); rd(8'h20, "R1"); rd(8'h24, "R1"); rd(8'h28, "R1");

        // R2: pending writes and readback
        wr(8'h20, 32'h0123_4567);
        wr(8'h24, 32'hF0AB_CDEF);
        wr(8'h28, 32'h0555_5555);
        wr(8'h04, 32'hFFFF_FFFF);
        // R3: no strobe yet, outputs unchanged
        step(1'b0, 8'h00, 32'h0, 1'b0, 1'b0, 1'b1, "R3");
        rd(8'h20, "R2"); rd(8'h24, "R2"); rd(8'h28, "R2"); rd(8'h04, "R2");

        // R10: unmapped accesses
        wr(8'h30, 32'hDEAD_BEEF);
        rd(8'h30, "R10"); rd(8'h20, "R10"); rd(8'h2C, "R10");

        // R5/R7: planar commit with unaligned offsets
        strobe("R7");
        step(1'b0, 8'h00, 32'h0, 1'b0, 1'b0, 1'b1, "R5");

        // R6: packed mode zeroes chroma bases
        wr(8'h04, 32'h0000_0000);
        strobe("R6");

        // R4: write coincident with the strobe waits one more strobe
        step(1'b1, 8'h20, 32'h0200_0000, 1'b0, 1'b1, 1'b1, "R4");
        strobe("R4");

        // R8/R9: field counter over three buffers
        frame_size = 28'h004_0000;
        wr(8'h20, 32'h3010_0000);
        strobe("R8"); strobe("R9"); strobe("R8"); strobe("R9");
        frame_size = 28'h008_0000;
        strobe("R9");
        // R9: wrap modulo 2^28 with limit 2
        wr(8'h20, 32'h2FFF_FFE7);
        frame_size = 28'h000_0040;
        strobe("R9"); strobe("R9");
        // R8: limit one forces the count to zero
        wr(8'h20, 32'h1000_0100);
        strobe("R8");
        // R3: a write without a strobe leaves outputs alone
        wr(8'h20, 32'h0FF0_0000);
        step(1'b0, 8'h00, 32'h0, 1'b0, 1'b0, 1'b1, "R3");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule